// File: doc/BRIEF.md
# Split-Access Interrupt Control Register

This block is a single 16-bit interrupt control register that serves five interrupt sources: synchronous serial, asynchronous serial, timer 2, timer 1 and external. One address has two meanings. A host write carries enable bits in its low byte and one-shot clear commands in its high byte. A host read returns which sources have a latched, pending event. It never returns the value that was last written.

Each source drives a one-cycle pulse input. A pulse sets that source's pending latch whether or not the source is enabled. The latch then holds until the host clears it. The block merges the enabled, pending sources into a single level interrupt towards the host. Picking a priority among sources and producing a vector are left to the consumer of the interrupt.

Top module: `irqc_split_reg`

## Requirements
- R1: A host write loads the enable register from write-data bits 4..0. Bit 4 is synchronous serial, bit 3 asynchronous serial, bit 2 timer 2, bit 1 timer 1 and bit 0 external. The new enables take effect after the clock edge of the write.
- R2: A host write with a 1 in bit 8+i clears pending latch i at that edge. A 0 in bit 8+i leaves latch i unchanged. Bits 12..8 use the same source order as bits 4..0.
- R3: A pulse on source input i sets pending latch i at the next edge. When a set and a clear reach the same latch in the same cycle, the set wins.
- R4: The read data shows the pending latches in bits 4..0, in the source order of R1. It never shows the written enables or clear bits.
- R5: The host interrupt output is high exactly when at least one source is both pending and enabled. It is driven from registered state only.
- R6: Read-data bits 15..5 always read as zero.
- R7: After reset, all enables and all pending latches are zero and the interrupt output is low.
- R8: The enable bits do not gate the pending latches. Disabling a pending source masks it from the interrupt output but keeps it pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe for the register |
| host_wdata | input | 16 | Write data: clears in bits 12..8, enables in bits 4..0 |
| host_rdata | output | 16 | Read data: pending status in bits 4..0, zero elsewhere |
| src_pulse | input | 5 | Per-source event pulses, bit order as R1 |
| host_irq | output | 1 | Combined interrupt towards the host |

## Verification
The assertions expect `src_pulse` and the write port to be synchronous to `clk`. They also expect every bit to be a defined 0 or 1 once reset is released. The set-wins and clear properties depend on this, because they reason about a single edge.

The bench drives all inputs on the falling edge, so each value is stable at the rising edge where it is used. Random phases also include collisions, where a source pulses in the same cycle as a write that clears it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_SRC = 5;
    localparam int REG_W   = 16;
    localparam int CLR_LSB = 8;
    localparam int EN_LSB  = 0;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t pend;
    } pend_state_t;

    typedef struct packed {
        src_vec_t en;
    } en_state_t;
endpackage

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    output src_vec_t pend_o
);
    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (set_i[i])
                st_d.pend[i] = 1'b1;
            else if (clr_i[i])
                st_d.pend[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]);
        p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !pend_o[g]);
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[g] && !set_i[g]) |=> $stable(pend_o[g]));
    end
endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  src_vec_t val_i,
    output src_vec_t en_o
);
    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.en = val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    p_enable_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (en_o == $past(val_i)));
    p_enable_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(en_o));
endmodule

// File: rtl/irqc_host_port.sv
module irqc_host_port
    import irqc_pkg::*;
#(
    parameter int DATA_W  = REG_W,
    parameter int CLR_POS = CLR_LSB,
    parameter int EN_POS  = EN_LSB
) (
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  src_vec_t          pend_i,
    output logic              en_load_o,
    output src_vec_t          en_val_o,
    output src_vec_t          clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int RD_PAD = DATA_W - NUM_SRC;

    always_comb begin
        en_load_o = wr_i;
        en_val_o  = wdata_i[EN_POS +: NUM_SRC];
        clr_o     = wr_i ? wdata_i[CLR_POS +: NUM_SRC] : '0;
        rdata_o   = {{RD_PAD{1'b0}}, pend_i};
    end

    always_comb begin
        p_zero_bits_r6: assert (rdata_o[DATA_W-1:NUM_SRC] == '0);
    end
endmodule

// File: rtl/irqc_split_reg.sv
module irqc_split_reg
    import irqc_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [NUM_SRC-1:0] src_pulse,
    output logic              host_irq
);
    src_vec_t pend, en, en_val, clr;
    logic     en_load;

    irqc_host_port #(.DATA_W(DATA_W)) u_port (
        .wr_i      (host_wr),
        .wdata_i   (host_wdata),
        .pend_i    (pend),
        .en_load_o (en_load),
        .en_val_o  (en_val),
        .clr_o     (clr),
        .rdata_o   (host_rdata)
    );

    irqc_enable_reg u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (en_load),
        .val_i  (en_val),
        .en_o   (en)
    );

    irqc_pend_bank u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_pulse),
        .clr_i  (clr),
        .pend_o (pend)
    );

    assign host_irq = |(pend & en);

    p_irq_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (host_rdata[NUM_SRC-1:0] != '0));
    p_pulse_raises_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pulse[0] && en[0] && !host_wr) |=> host_irq);
endmodule

// File: tb/irqc_split_reg_bench.sv
module irqc_split_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [4:0]  src_pulse = '0;
    logic        host_irq;

    int checks = 0;
    int failures = 0;
    logic [4:0] ref_en = '0;
    logic [4:0] ref_pend = '0;
    bit done = 0;

    always #10 clk = ~clk;

    irqc_split_reg u_irqc_split_reg (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .src_pulse(src_pulse), .host_irq(host_irq)
    );

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_en   <= '0;
            ref_pend <= '0;
        end else begin
            logic [4:0] p;
            p = ref_pend;
            for (int i = 0; i < 5; i++) begin
                if (host_wr && host_wdata[8+i]) p[i] = 1'b0;
                if (src_pulse[i]) p[i] = 1'b1;
            end
            ref_pend <= p;
            if (host_wr) ref_en <= host_wdata[4:0];
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference (R4, R5, R6)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 readback", host_rdata, {11'b0, ref_pend});
            check("R5 irq", {15'b0, host_irq}, {15'b0, |(ref_en & ref_pend)});
        end
    end

    task automatic step(input logic wr, input logic [15:0] wd, input logic [4:0] p);
        @(negedge clk);
        host_wr = wr; host_wdata = wd; src_pulse = p;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0; src_pulse = '0;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 rdata after reset", host_rdata, 16'h0000);
        check("R7 irq after reset", {15'b0, host_irq}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 / R3: pulses latch with all enables off, irq stays low
        step(1'b0, 16'h0, 5'b10101);
        check("R3 pend set with enables off", host_rdata, 16'h0015);
        check("R8 irq masked", {15'b0, host_irq}, 16'h0);
        // R1: enable timer 1 only (bit 1), not pending -> low; then enable external (bit 0)
        step(1'b1, 16'h0002, 5'b0);
        check("R1 enable non-pending source", {15'b0, host_irq}, 16'h0);
        check("R4 write not visible", host_rdata, 16'h0015);
        step(1'b1, 16'h0001, 5'b0);
        check("R1 enable pending external", {15'b0, host_irq}, 16'h1);
        // R2: clear external only (bit 8), zeros elsewhere do nothing
        step(1'b1, 16'h0101, 5'b0);
        check("R2 clear external", host_rdata, 16'h0014);
        check("R5 irq drops after clear", {15'b0, host_irq}, 16'h0);
        // R3: set and clear of sync serial in the same cycle -> set wins
        step(1'b1, 16'h1010, 5'b10000);
        check("R3 set beats clear", host_rdata, 16'h0014);
        check("R5 irq sync serial", {15'b0, host_irq}, 16'h1);
        // R8: disabling keeps pending
        step(1'b1, 16'h0000, 5'b0);
        check("R8 pending kept after disable", host_rdata, 16'h0014);
        check("R8 irq masked after disable", {15'b0, host_irq}, 16'h0);
        // R6: all ones written, upper bits must read zero
        step(1'b0, 16'h0, 5'b11111);
        step(1'b1, 16'hFFFF, 5'b11111);
        check("R6 unused bits zero", host_rdata & 16'hFFE0, 16'h0000);
        // R2: clear all
        step(1'b1, 16'h1F00, 5'b0);
        check("R2 clear all", host_rdata, 16'h0000);
        // random phase with collisions, checked every cycle
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            host_wr    = ($urandom_range(0, 3) == 0);
            host_wdata = 16'($urandom);
            src_pulse  = ($urandom_range(0, 2) == 0) ? 5'($urandom) : 5'b0;
        end
        @(negedge clk);
        host_wr = 1'b0; src_pulse = '0;
        // R7: reset mid-operation
        step(1'b1, 16'h001F, 5'b11111);
        rst_n = 1'b0;
        #1;
        check("R7 rdata after second reset", host_rdata, 16'h0000);
        check("R7 irq after second reset", {15'b0, host_irq}, 16'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule